// File: doc/BRIEF.md
# Fast-Page-Mode DRAM Controller with CAS-before-RAS Refresh

This block connects a synchronous request/acknowledge port to one asynchronous fast-page-mode DRAM bank. A requester presents a 22-bit word address, a read/write flag and write data, then holds the request until a one-clock acknowledge. The controller splits the address into a row part and a column part according to a runtime mode pin. It puts the row on the multiplexed address pins with the row strobe, then the column with the column strobe. For a read it captures the data bus in the last column-strobe cycle.

A free-running interval timer schedules CAS-before-RAS refresh cycles. The DRAM's own counter chooses the row, so the address pins carry zero during refresh. A refresh that falls due while an access is running waits for that access to finish. It then runs ahead of any waiting request. All strobe timings are parameters in clock cycles: the row-to-column delay, the column pulse width, the precharge, the column-before-row setup and the refresh row pulse. The refresh interval is also a clock count. With the default clock count and a 50 MHz clock it gives one refresh every 15.6 us, which covers 2048 rows in 32 ms and 4096 rows in 64 ms.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While rst_ni is low and afterwards until the first access, dram_ras_no, dram_cas_no and dram_we_no are high, ack_o is low and dram_addr_o is zero.
- R2: With mode_i = 0 (11 row / 11 column bits), the row presented on dram_addr_o[10:0] is addr_i[21:11] and the column is addr_i[10:0]; pin 11 is zero in both phases.
- R3: With mode_i = 1 (12 row / 10 column bits), the row on dram_addr_o[11:0] is addr_i[21:10] and the column on dram_addr_o[9:0] is addr_i[9:0] with pins 11:10 zero; mode_i is sampled only in the clock that accepts the request.
- R4: An access drives dram_ras_no low for T_RCD clocks before dram_cas_no falls, holds CAS low for T_CAS clocks, and raises ack_o in the clock where CAS rises. With an idle controller, ack_o is therefore seen T_RCD+T_CAS+1 clocks after the request is raised.
- R5: For a read, rdata_o in the ack_o clock equals dram_dq_i as sampled in the last CAS-low clock.
- R6: ack_o is high for exactly one clock per access. A request is held until its ack, and no second access starts before it.
- R7: A refresh drives dram_cas_no low at least one clock before dram_ras_no falls, keeps dram_we_no high, and drives dram_addr_o to zero.
- R8: Refreshes start on average once per REF_INTERVAL clocks, whether the port is idle or busy. A due refresh is started before the next pending request, and no two refreshes are more than REF_INTERVAL plus one access and one refresh length apart.
- R9: On a write, dram_we_no is low and dram_dq_oe_o is high from the clock RAS falls through the CAS pulse, with dram_dq_o carrying wdata_i. On a read, dram_we_no stays high and dram_dq_oe_o stays low.
- R10: dram_ras_no stays high for at least T_RP clocks between any two RAS-low periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until ack_o |
| we_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 1 | Address split: 0 = 11/11, 1 = 12/10 |
| addr_i | input | AW (22) | Word address |
| wdata_i | input | DW (4) | Write data |
| ack_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DW (4) | Read data, valid with ack_o |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_addr_o | output | PW (12) | Multiplexed row/column address |
| dram_dq_o | output | DW (4) | Data to DRAM |
| dram_dq_oe_o | output | 1 | Data output enable |
| dram_dq_i | input | DW (4) | Data from DRAM |

## Verification
The assertions watch the pin-level timing on every clock. They check the row-to-column delay, the precharge floor, the CAS-before-RAS order with WE high and a zero address, the WE setup before CAS on writes, and the one-clock ack that coincides with CAS rising. They also bound the spacing between refreshes. Only the bench scenarios can show the data side: that walking-one, all-ones and all-zero addresses reach the right row and column pins in both split modes, that a mode change after acceptance is ignored, that read data returns what was written, and that the average refresh count matches the interval in idle and busy stretches.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    ST_PRE  = 3'd0,
    ST_IDLE = 3'd1,
    ST_ROW  = 3'd2,
    ST_COL  = 3'd3,
    ST_RCAS = 3'd4,
    ST_RRAS = 3'd5
  } seq_state_e;

  typedef enum logic {
    SPLIT_11_11 = 1'b0,
    SPLIT_12_10 = 1'b1
  } split_mode_e;
endpackage

// File: rtl/fpm_addr_split.sv
module fpm_addr_split #(
  parameter int AW = 22,
  parameter int RN = 11,
  parameter int PW = 12
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wide_row_i,
  output logic [PW-1:0] row_o,
  output logic [PW-1:0] col_o
);
  localparam int CN = AW - RN;  // column bits with narrow row
  localparam int CM = CN - 1;   // column bits with wide row

  always_comb begin
    row_o = '0;
    col_o = '0;
    if (wide_row_i) begin
      row_o[RN:0]   = addr_i[AW-1:CM];
      col_o[CM-1:0] = addr_i[CM-1:0];
    end else begin
      row_o[RN-1:0] = addr_i[AW-1:CN];
      col_o[CN-1:0] = addr_i[CN-1:0];
    end
  end
endmodule

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
  parameter int INTERVAL = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  output logic due_o
);
  localparam int TW = $clog2(INTERVAL + 1);
  typedef logic [TW-1:0] tcnt_t;

  tcnt_t cnt_q;
  logic  due_q;
  logic  wrap;

  assign wrap  = (cnt_q == '0);
  assign due_o = due_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= tcnt_t'(INTERVAL - 1);
      due_q <= 1'b0;
    end else begin
      cnt_q <= wrap ? tcnt_t'(INTERVAL - 1) : cnt_q - 1'b1;
      // a new expiry wins over a take in the same clock
      due_q <= wrap | (due_q & ~take_i);
    end
  end
endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RP  = 2,
  parameter int T_CSR = 1,
  parameter int T_RFH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic we_i,
  input  logic ref_due_i,
  output logic accept_o,
  output logic ref_take_o,
  output logic capture_o,
  output logic row_sel_o,
  output logic col_sel_o,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic dq_oe_o,
  output logic ack_o
);
  localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2   = (M1 > T_RP) ? M1 : T_RP;
  localparam int M3   = (M2 > T_CSR) ? M2 : T_CSR;
  localparam int TMAX = (M3 > T_RFH) ? M3 : T_RFH;
  localparam int CW   = $clog2(TMAX + 1);
  typedef logic [CW-1:0] cnt_t;

  seq_state_e state_q, state_d;
  cnt_t       cnt_q, cnt_d;
  logic       wr_q, wr_d;
  logic       last;
  logic       ras_q, cas_q, we_q, oe_q, ack_q;
  logic       ras_d, cas_d, we_d, oe_d, ack_d;

  assign last = (cnt_q == '0);

  always_comb begin
    state_d    = state_q;
    cnt_d      = last ? '0 : cnt_q - 1'b1;
    wr_d       = wr_q;
    accept_o   = 1'b0;
    ref_take_o = 1'b0;
    ack_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_due_i) begin
          state_d    = ST_RCAS;
          cnt_d      = cnt_t'(T_CSR - 1);
          ref_take_o = 1'b1;
        end else if (req_i) begin
          state_d  = ST_ROW;
          cnt_d    = cnt_t'(T_RCD - 1);
          wr_d     = we_i;
          accept_o = 1'b1;
        end
      end
      ST_ROW: if (last) begin
        state_d = ST_COL;
        cnt_d   = cnt_t'(T_CAS - 1);
      end
      ST_COL: if (last) begin
        state_d = ST_PRE;
        cnt_d   = cnt_t'(T_RP - 1);
        ack_d   = 1'b1;
      end
      ST_RCAS: if (last) begin
        state_d = ST_RRAS;
        cnt_d   = cnt_t'(T_RFH - 1);
      end
      ST_RRAS: if (last) begin
        state_d = ST_PRE;
        cnt_d   = cnt_t'(T_RP - 1);
      end
      ST_PRE: if (last) state_d = ST_IDLE;
      default: begin
        state_d = ST_PRE;
        cnt_d   = cnt_t'(T_RP - 1);
      end
    endcase
  end

  assign capture_o = ack_d & ~wr_q;
  assign row_sel_o = (state_d == ST_ROW);
  assign col_sel_o = (state_d == ST_COL);

  // pins are registered from the next state so they never glitch
  always_comb begin
    ras_d = ~(state_d == ST_ROW || state_d == ST_COL || state_d == ST_RRAS);
    cas_d = ~(state_d == ST_COL || state_d == ST_RCAS || state_d == ST_RRAS);
    oe_d  = (state_d == ST_ROW || state_d == ST_COL) && wr_d;
    we_d  = ~oe_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PRE;
      cnt_q   <= cnt_t'(T_RP - 1);
      wr_q    <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      we_q    <= 1'b1;
      oe_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wr_q    <= wr_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
      we_q    <= we_d;
      oe_q    <= oe_d;
      ack_q   <= ack_d;
    end
  end

  assign ras_no  = ras_q;
  assign cas_no  = cas_q;
  assign we_no   = we_q;
  assign dq_oe_o = oe_q;
  assign ack_o   = ack_q;
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int DW           = 4,
  parameter int AW           = 22,
  parameter int ROW_NARROW   = 11,
  parameter int REF_INTERVAL = 780,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_CSR        = 1,
  parameter int T_RFH        = 3,
  localparam int PW = ((ROW_NARROW + 1) > (AW - ROW_NARROW)) ? (ROW_NARROW + 1)
                                                             : (AW - ROW_NARROW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ack_o,
  output logic [DW-1:0] rdata_o,
  output logic          dram_ras_no,
  output logic          dram_cas_no,
  output logic          dram_we_no,
  output logic [PW-1:0] dram_addr_o,
  output logic [DW-1:0] dram_dq_o,
  output logic          dram_dq_oe_o,
  input  logic [DW-1:0] dram_dq_i
);
  logic          accept, ref_take, ref_due, capture, row_sel, col_sel;
  logic [AW-1:0] addr_q, src_addr;
  logic          wide_q, src_wide;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [PW-1:0] row_w, col_w, pin_addr_q;

  fpm_ref_timer #(.INTERVAL(REF_INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (ref_take),
    .due_o  (ref_due)
  );

  fpm_seq #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFH(T_RFH)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .ref_due_i  (ref_due),
    .accept_o   (accept),
    .ref_take_o (ref_take),
    .capture_o  (capture),
    .row_sel_o  (row_sel),
    .col_sel_o  (col_sel),
    .ras_no     (dram_ras_no),
    .cas_no     (dram_cas_no),
    .we_no      (dram_we_no),
    .dq_oe_o    (dram_dq_oe_o),
    .ack_o      (ack_o)
  );

  // row pins are launched in the accepting clock, before addr_q loads
  assign src_addr = accept ? addr_i : addr_q;
  assign src_wide = accept ? mode_i : wide_q;

  fpm_addr_split #(.AW(AW), .RN(ROW_NARROW), .PW(PW)) u_split (
    .addr_i     (src_addr),
    .wide_row_i (src_wide),
    .row_o      (row_w),
    .col_o      (col_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q     <= '0;
      wide_q     <= SPLIT_11_11;
      wdata_q    <= '0;
      rdata_q    <= '0;
      pin_addr_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wide_q  <= mode_i;
        wdata_q <= wdata_i;
      end
      if (capture) rdata_q <= dram_dq_i;
      pin_addr_q <= row_sel ? row_w : (col_sel ? col_w : '0);
    end
  end

  assign dram_addr_o = pin_addr_q;
  assign dram_dq_o   = wdata_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int REF_INTERVAL = 780,
  parameter int T_RCD        = 2,
  parameter int T_CAS        = 2,
  parameter int T_RP         = 2,
  parameter int T_CSR        = 1,
  parameter int T_RFH        = 3,
  parameter int PW           = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ack_o,
  input logic          dram_ras_no,
  input logic          dram_cas_no,
  input logic          dram_we_no,
  input logic          dram_dq_oe_o,
  input logic [PW-1:0] dram_addr_o
);
  localparam int LIMIT = REF_INTERVAL + T_RCD + T_CAS + T_RP + T_CSR + T_RFH + 4;

  logic [15:0] hi_cnt, lo_cnt;
  logic [31:0] since_ref;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt    <= '0;
      lo_cnt    <= '0;
      since_ref <= '0;
    end else begin
      hi_cnt <= dram_ras_no ? ((hi_cnt == 16'hFFFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      lo_cnt <= !dram_ras_no ? ((lo_cnt == 16'hFFFF) ? lo_cnt : lo_cnt + 1'b1) : '0;
      since_ref <= (!dram_cas_no && dram_ras_no) ? '0 : since_ref + 1'b1;
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o); // R6
  AST_ACK_AT_CAS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (dram_cas_no && $past(!dram_cas_no) && $past(!dram_ras_no))); // R4
  AST_RCD_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_ras_no) |-> (32'(lo_cnt) >= T_RCD)); // R4
  AST_PRECHARGE_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dram_ras_no) |-> (32'(hi_cnt) >= T_RP)); // R10
  AST_CBR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && !dram_cas_no) |-> $past(!dram_cas_no)); // R7
  AST_REF_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_ras_no) && !dram_cas_no) |-> (dram_addr_o == '0)); // R7
  AST_REF_WE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dram_cas_no && dram_ras_no) |-> (dram_we_no && !dram_dq_oe_o)); // R7
  AST_WE_SETUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(dram_cas_no) && !dram_ras_no && !dram_we_no) |-> $past(!dram_we_no && dram_dq_oe_o)); // R9
  AST_OE_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dram_dq_oe_o |-> (!dram_we_no && !dram_ras_no)); // R9
  AST_REF_DEADLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_ref < 32'(LIMIT))); // R8
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .REF_INTERVAL(REF_INTERVAL), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
  .T_CSR(T_CSR), .T_RFH(T_RFH), .PW(PW)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ack_o        (ack_o),
  .dram_ras_no  (dram_ras_no),
  .dram_cas_no  (dram_cas_no),
  .dram_we_no   (dram_we_no),
  .dram_dq_oe_o (dram_dq_oe_o),
  .dram_addr_o  (dram_addr_o)
);

// File: tb/fpm_dram_ctrl_bench.sv
module fpm_dram_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 4, AW = 22, PW = 12;
  localparam int REF_INT = 40;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_CSR = 1, T_RFH = 3;
  localparam int LAT = T_RCD + T_CAS + 1;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0, mode = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, dq_o, dq_in = '0;
  logic          ack, ras_n, cas_n, we_n, dq_oe;
  logic [PW-1:0] dram_addr;

  fpm_dram_ctrl #(
    .DW(DW), .AW(AW), .ROW_NARROW(11), .REF_INTERVAL(REF_INT),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFH(T_RFH)
  ) u_fpm_dram_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .mode_i(mode),
    .addr_i(addr), .wdata_i(wdata), .ack_o(ack), .rdata_o(rdata),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n),
    .dram_addr_o(dram_addr), .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe),
    .dram_dq_i(dq_in)
  );

  int vec = 0, bad = 0, cyc = 0, ref_cnt = 0;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] dflt(input logic [AW-1:0] a);
    return a[3:0] ^ a[11:8] ^ a[21:18];
  endfunction

  // behavioural DRAM, sampled between clock edges
  logic [DW-1:0] mem [int];
  logic [AW-1:0] exp_addr = '0;
  logic          exp_mode = 1'b0, exp_wr = 1'b0;
  logic          p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [PW-1:0] row_lat = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        if (!cas_n) begin
          ref_cnt++;
          chk(p_cas == 1'b0, "R7 cas before ras", p_cas, 0);
          chk(dram_addr == '0 && we_n, "R7 refresh addr/we", dram_addr, 0);
        end else row_lat = dram_addr;
      end
      if (p_cas && !cas_n && !ras_n) begin
        logic [PW-1:0] er, ec;
        logic [AW-1:0] a;
        er = exp_mode ? PW'(exp_addr >> 10) : PW'(exp_addr >> 11);
        ec = exp_mode ? PW'(exp_addr & 22'h3FF) : PW'(exp_addr & 22'h7FF);
        chk(row_lat == er, exp_mode ? "R3 row pins" : "R2 row pins", row_lat, er);
        chk(dram_addr == ec, exp_mode ? "R3 col pins" : "R2 col pins", dram_addr, ec);
        a = exp_mode ? {row_lat[11:0], dram_addr[9:0]} : {row_lat[10:0], dram_addr[10:0]};
        if (exp_wr) begin
          chk(!we_n && !p_we && dq_oe, "R9 write we/oe before cas", {we_n, p_we, dq_oe}, 3'b001);
          mem[int'(a)] = dq_o;
        end else begin
          chk(we_n && !dq_oe, "R9 read we high", {we_n, dq_oe}, 2'b10);
          dq_in = mem.exists(int'(a)) ? mem[int'(a)] : dflt(a);
        end
      end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  task automatic access(input bit m, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit flip, output logic [DW-1:0] rd);
    int r0, lat;
    r0 = ref_cnt; lat = 0;
    exp_addr = a; exp_mode = m; exp_wr = w;
    mode = m; we = w; addr = a; wdata = d; req = 1'b1;
    do begin
      @(negedge clk);
      lat++;
      // change mode after the row was strobed: must not matter (R3)
      if (flip && !ras_n && cas_n) mode = ~m;
    end while (!ack && lat < 100);
    chk(ack, "R6 ack seen", ack, 1);
    rd = rdata;
    req = 1'b0;
    if (ref_cnt == r0) chk(lat == LAT, "R4 ack latency", lat, LAT);
    @(negedge clk);
    chk(!ack, "R6 ack one clock", ack, 0);
    repeat (T_RP - 1) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [DW-1:0] rd;
    logic [AW-1:0] a;
    int c0, r0, ex;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && !ack && dram_addr == '0, "R1 reset pins",
        {ras_n, cas_n, we_n, ack}, 4'b1110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n && cas_n && we_n && !ack, "R1 after release", {ras_n, cas_n, we_n, ack}, 4'b1110);
    repeat (T_RP) @(negedge clk);

    // unwritten location returns the model's default pattern (R5)
    access(1'b0, 1'b0, 22'h155555, 4'h0, 1'b0, rd);
    chk(rd == dflt(22'h155555), "R5 default read", rd, dflt(22'h155555));

    c0 = cyc; r0 = ref_cnt;
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 24; i++) begin
        a = (i < 22) ? AW'(1) << i : ((i == 22) ? '1 : '0);
        access(m[0], 1'b1, a, DW'(i * 3 + m * 5 + 1), i[0], rd);
      end
      for (int i = 0; i < 24; i++) begin
        a = (i < 22) ? AW'(1) << i : ((i == 22) ? '1 : '0);
        access(m[0], 1'b0, a, '0, ~i[0], rd);
        chk(rd == DW'(i * 3 + m * 5 + 1), "R5 readback", rd, DW'(i * 3 + m * 5 + 1));
      end
    end
    ex = (cyc - c0) / REF_INT;
    chk((ref_cnt - r0) >= ex - 1 && (ref_cnt - r0) <= ex + 1, "R8 busy refresh count",
        ref_cnt - r0, ex);

    c0 = cyc; r0 = ref_cnt;
    repeat (20 * REF_INT) @(negedge clk);
    ex = (cyc - c0) / REF_INT;
    chk((ref_cnt - r0) >= ex - 1 && (ref_cnt - r0) <= ex + 1, "R8 idle refresh count",
        ref_cnt - r0, ex);
    chk(ras_n && !dq_oe, "R10 idle ras high", {ras_n, dq_oe}, 2'b10);

    // back-to-back on one row, alternating data
    for (int k = 0; k < 8; k++) begin
      access(k[1], 1'b1, 22'h2AAAAA ^ AW'(k), DW'(k ^ 5), 1'b0, rd);
      access(k[1], 1'b0, 22'h2AAAAA ^ AW'(k), '0, 1'b0, rd);
      chk(rd == DW'(k ^ 5), "R5 alternating", rd, DW'(k ^ 5));
    end
    report();
  end
endmodule